// File: doc/BRIEF.md
# Sequential Signed Multiplier with Booth and Shift-Add Modes

This block multiplies two signed two's complement operands of `WIDTH` bits and returns their signed `2*WIDTH`-bit product after `WIDTH` steps. A pulse on `start` while the block is idle captures the multiplicand, the multiplier and the method. From then on, each clock performs one add, subtract or hold on an accumulator, followed by an arithmetic right shift of the accumulator and the multiplier register joined together.

Two methods share the one adder/subtractor and the one shift path. With `mode` = 0 (Booth), the low multiplier bit and a trailing bit below it select the operation: 01 adds, 10 subtracts, and 00 or 11 holds. With `mode` = 1 (shift-add), each step with a low multiplier bit of 1 adds the multiplicand. The step that sees the multiplier's sign bit, which is the last step, subtracts instead. The accumulator carries one guard bit so that the most negative operands cannot wrap it.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` = 0, `done` = 0 and `product` = 0 until the first accepted start.
- R2: `start` = 1 with `busy` = 0 is accepted on that clock edge. `busy` is 1 from the next cycle for exactly `WIDTH` cycles, and `done` rises in the cycle after `busy` falls.
- R3: With `mode` = 0 (Booth recoding) at the accepted start, `product` equals the signed product of `multiplicand` and `multiplier` while `done` = 1, for all operand values, the most negative included.
- R4: With `mode` = 1 (shift-add, final-step subtract for a negative multiplier), `product` equals the same signed product while `done` = 1, for all operand values.
- R5: `done` lasts exactly one cycle, and `busy` and `done` are never 1 together.
- R6: While `busy` = 1, `start`, `mode` and both operands have no effect. The running operation completes on schedule with the result of the operands captured at its accepted start.
- R7: `product` holds its value from the `done` cycle until the next accepted start.
- R8: With `WIDTH` = 8, the multiplicand 3 and the multiplier -5 give `product` = 16'hFFF1 (-15) in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| mode | input | 1 | 0 = Booth recoding, 1 = shift-add with sign-step subtract |
| multiplicand | input | WIDTH | Signed multiplicand, captured at accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured at accepted start |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse after the final step |
| product | output | 2*WIDTH | Signed product {accumulator, multiplier register} |

## Verification
The bench builds the block with `WIDTH` = 8. At that width, the extreme pairs (-128 × -128, -128 × 127 and the others) are cheap to drive directly in both modes, and several hundred random pairs per mode sample the rest of the 64K operand space. A bench function computes the expected signed product. The bench also measures the latency, the width of the `done` pulse and how long the result holds. It injects a second start with inverted operands and the other mode in the middle of a run, to show that the request is ignored.

// File: rtl/mul_pkg.sv
package mul_pkg;
   typedef enum logic {
      MODE_BOOTH    = 1'b0,
      MODE_SHIFTADD = 1'b1
   } mul_mode_e;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2
   } step_op_e;
endpackage

// File: rtl/mul_step_decode.sv
module mul_step_decode
   import mul_pkg::*;
(
   input  mul_mode_e mode,
   input  logic      q_lsb,
   input  logic      q_trail,
   input  logic      last_step,
   output step_op_e  op
);
   always_comb begin
      op = OP_HOLD;
      unique case (mode)
         MODE_BOOTH: begin
            unique case ({q_lsb, q_trail})
               2'b01:   op = OP_ADD;
               2'b10:   op = OP_SUB;
               default: op = OP_HOLD;
            endcase
         end
         MODE_SHIFTADD: begin
            if (q_lsb) op = last_step ? OP_SUB : OP_ADD;
         end
         default: op = OP_HOLD;
      endcase
   end
endmodule

// File: rtl/mul_addsub.sv
module mul_addsub #(
   parameter int W = 9
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  logic         sub,
   output logic [W-1:0] sum
);
   logic [W-1:0] rhs_x;
   always_comb begin
      rhs_x = rhs ^ {W{sub}};
      sum   = lhs + rhs_x + W'(sub);
   end
endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl #(
   parameter int STEPS = 8,
   localparam int CNT_W = $clog2(STEPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic busy,
   output logic done,
   output logic last_step
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0] step_cnt;

   assign accept    = start && !busy;
   assign last_step = (step_cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_cnt <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            step_cnt <= '0;
         end else if (busy) begin
            step_cnt <= step_cnt + 1'b1;
            if (last_step) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
   import mul_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 mode,
   input  logic [WIDTH-1:0]     multiplicand,
   input  logic [WIDTH-1:0]     multiplier,
   output logic                 busy,
   output logic                 done,
   output logic [2*WIDTH-1:0]   product
);
   localparam int AW = WIDTH + 1;   // accumulator with one guard bit

   if (WIDTH < 2) begin : g_width_check
      $error("booth_seq_mult: WIDTH must be at least 2");
   end

   logic          accept, last_step;
   logic [AW-1:0] acc, mcand, alu_sum, alu_res;
   logic [WIDTH-1:0] q_reg;
   logic          q_trail;
   mul_mode_e     mode_r;
   step_op_e      op;

   mul_seq_ctrl #(.STEPS(WIDTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .accept    (accept),
      .busy      (busy),
      .done      (done),
      .last_step (last_step)
   );

   mul_step_decode u_dec (
      .mode      (mode_r),
      .q_lsb     (q_reg[0]),
      .q_trail   (q_trail),
      .last_step (last_step),
      .op        (op)
   );

   mul_addsub #(.W(AW)) u_alu (
      .lhs (acc),
      .rhs (mcand),
      .sub (op == OP_SUB),
      .sum (alu_sum)
   );

   assign alu_res = (op == OP_HOLD) ? acc : alu_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         mcand   <= '0;
         q_reg   <= '0;
         q_trail <= 1'b0;
         mode_r  <= MODE_BOOTH;
      end else if (accept) begin
         acc     <= '0;
         mcand   <= {multiplicand[WIDTH-1], multiplicand};
         q_reg   <= multiplier;
         q_trail <= 1'b0;
         mode_r  <= mul_mode_e'(mode);
      end else if (busy) begin
         acc     <= {alu_res[AW-1], alu_res[AW-1:1]};
         q_reg   <= {alu_res[0], q_reg[WIDTH-1:1]};
         q_trail <= q_reg[0];
      end
   end

   assign product = {acc[WIDTH-1:0], q_reg};
endmodule

// File: rtl/mul_seq_checker.sv
module mul_seq_checker #(
   parameter int WIDTH = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [WIDTH-1:0]   multiplicand,
   input logic [WIDTH-1:0]   multiplier,
   input logic               busy,
   input logic               done,
   input logic [2*WIDTH-1:0] product
);
   localparam int CW = $clog2(WIDTH + 2);

   logic [CW-1:0] busy_cnt;
   logic signed [2*WIDTH-1:0] golden;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         golden   <= '0;
      end else if (start && !busy) begin
         busy_cnt <= '0;
         golden   <= $signed(multiplicand) * $signed(multiplier);
      end else if (busy) begin
         busy_cnt <= busy_cnt + 1'b1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (!busy && !done && product == '0));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == CW'(WIDTH)));

   // R4 is covered by the same check: the golden value does not depend on mode
   assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product == golden));

   assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_cnt < CW'(WIDTH - 1)) |=> busy);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mult mul_seq_checker #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .multiplicand (multiplicand),
   .multiplier   (multiplier),
   .busy         (busy),
   .done         (done),
   .product      (product)
);

// File: tb/tb_booth_seq_mult.sv
module tb_booth_seq_mult;
   localparam int W = 8;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mode = 1'b0;
   logic [W-1:0] mcand = '0, mplier = '0;
   logic busy, done;
   logic [2*W-1:0] product;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   booth_seq_mult #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .multiplicand(mcand), .multiplier(mplier),
      .busy(busy), .done(done), .product(product)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic signed [2*W-1:0] sa, sb;
      sa = {{W{a[W-1]}}, a};
      sb = {{W{b[W-1]}}, b};
      return sa * sb;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic md, input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit poke, input bit verbose);
      int lat;
      logic [2*W-1:0] exp, held;
      exp = ref_mul(a, b);
      @(negedge clk);
      start = 1'b1; mode = md; mcand = a; mplier = b;
      @(negedge clk);
      start = 1'b0;
      if (verbose) check(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
      lat = 1;
      while (!done && lat < 4*W) begin
         if (poke && lat == 3) begin
            start = 1'b1; mode = ~md; mcand = ~a; mplier = ~b;   // R6 request while busy
         end
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      if (verbose) check(lat == W + 1, "R2 latency", 32'(lat), 32'(W + 1));
      if (md == 1'b0)
         check(product == exp, poke ? "R6 Booth result after ignored start" : "R3 Booth product",
               32'(product), 32'(exp));
      else
         check(product == exp, poke ? "R6 shift-add result after ignored start" : "R4 shift-add product",
               32'(product), 32'(exp));
      held = product;
      @(negedge clk);
      if (verbose) begin
         check(done == 1'b0, "R5 done one cycle", 32'(done), 32'd0);
         check(busy == 1'b0, "R5 idle after done", 32'(busy), 32'd0);
      end
      repeat (2) @(negedge clk);
      if (verbose) check(product == held, "R7 product holds", 32'(product), 32'(held));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] ra, rb;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0, "R1 reset outputs", {busy, done}, 32'd0);
      check(product == '0, "R1 reset product", 32'(product), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(product == '0 && !busy, "R1 idle after release", 32'(product), 32'd0);

      for (int m = 0; m < 2; m++) begin
         run_op(m[0], 8'd3, 8'hFB, 1'b0, 1'b1);
         check(product == 16'hFFF1, "R8 3 x -5", 32'(product), 32'hFFF1);
         run_op(m[0], 8'h80, 8'h80, 1'b0, 1'b1);
         run_op(m[0], 8'h80, 8'h7F, 1'b0, 1'b0);
         run_op(m[0], 8'h7F, 8'h80, 1'b0, 1'b0);
         run_op(m[0], 8'h00, 8'h80, 1'b0, 1'b0);
         run_op(m[0], 8'hFF, 8'hFF, 1'b0, 1'b0);
         run_op(m[0], 8'h80, 8'h01, 1'b0, 1'b0);
         run_op(m[0], 8'h7F, 8'h7F, 1'b0, 1'b0);
         run_op(m[0], 8'h55, 8'hAA, 1'b1, 1'b1);
      end

      for (int i = 0; i < 600; i++) begin
         ra = W'($urandom);
         rb = W'($urandom);
         run_op(i[0], ra, rb, (i % 50) == 7, (i % 40) == 0);
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule